// File: doc/BRIEF.md
# Predictive Reference Phase Delay Controller

This block runs on the retimed reference clock of a phase-domain digital frequency synthesizer. Every reference cycle it adds an unsigned fixed-point frequency command word into a reference phase accumulator. Phase is counted in oscillator periods: integer periods above the binary point and a fraction of one period below it. An optional phase-modulation offset is added to the fractional phase only.

From that fraction the block predicts how long the reference edge must be delayed so that it lands on the next oscillator edge. It complements the fractional phase and multiplies the result by an inverse-gain estimate of the delay converter. This gives a fixed-point delay value whose integer part drives the converter. The fraction left over can be treated in one of two ways. A first-order sigma-delta modulator can fold it into the integer code. Otherwise it is passed on as a signed residue for the fine time-to-digital result to absorb. The carry out of the fractional accumulator is passed on for a downstream edge swallower.

Top module: `refdelay_predictor`

## Requirements
- R1: On each clock without reset, the 24-bit phase state (bits 23:16 integer, 15:0 fraction) grows by the command word in the same 8.16 format, modulo 2^24.
- R2: Outputs are registered. The values seen after clock edge n show the phase state held before edge n, so the first edge after reset shows phase zero.
- R3: `carry_o` is 1 exactly when the fractional addition that produced the shown phase overflowed bit 15.
- R4: `ref_frac_o` equals the state fraction plus `pm_ofs_i` modulo 2^16. The offset affects neither `ref_int_o` nor the accumulated state.
- R5: The delay value is D = ((~ref_frac) / 2^16) x (`inv_gain_i` / 2^16), where `inv_gain_i` is unsigned 8.16. With dithering off, `dtc_code_o` = floor(D).
- R6: If floor(D) exceeds 63, the code is 63 and the leftover fraction is taken as zero.
- R7: With dithering off, `residue_o` = 2^15 - F, where F is the top 16 fractional bits of D. It is a signed 17-bit value in units of 2^-16 of a code step, so it lies in (-2^15, 2^15].
- R8: With dithering on, a 16-bit accumulator adds F each cycle. Its carry adds 1 to floor(D), and the code is held at 63 if it is already there. `residue_o` is 0 on the next output.
- R9: A cycle with dithering off clears the sigma-delta accumulator, so the next dithered cycle starts from zero.
- R10: A synchronous active-high reset clears the phase state, the carry, the sigma-delta state and all outputs to zero.
- R11: With a command word of 2.25 (0x024000) and an inverse gain of 4.0 (0x040000), the code repeats 3, 2, 1, 0 starting from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_i | input | 24 | Frequency command word, unsigned 8.16 |
| inv_gain_i | input | 24 | Inverse converter gain, unsigned 8.16 |
| pm_ofs_i | input | 16 | Phase-modulation offset added to the fraction, two's complement |
| dither_en_i | input | 1 | 1: sigma-delta folding, 0: residue output |
| ref_int_o | output | 8 | Integer reference phase |
| ref_frac_o | output | 16 | Fractional reference phase including the offset |
| carry_o | output | 1 | Fractional accumulator carry |
| dtc_code_o | output | 6 | Delay converter code |
| residue_o | output | 17 | Signed prediction residue |

## Verification
The first directed case is the 2.25 command word with a gain of 4.0. Its descending code ladder shows that the complement is taken rather than the raw fraction. It also shows the one-cycle output alignment right after reset. A large gain with a tiny fraction separates correct clamping from wraparound of the code. Runs with a constant delay fraction and dithering switched on and off show the carry pattern of the modulator and the clearing of its state. A long seeded random run then mixes command words, gains, offsets and mode changes. It exposes errors in the accumulator carry, in the offset wrap and in the residue sign.

// File: rtl/refdelay_pkg.sv
package refdelay_pkg;
   typedef enum logic {
      SHAPE_RESIDUE = 1'b0,
      SHAPE_DITHER  = 1'b1
   } shape_mode_e;
endpackage

// File: rtl/refdelay_phase_acc.sv
module refdelay_phase_acc #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [INT_W+FRAC_W-1:0] fcw,
   output logic [INT_W+FRAC_W-1:0] phase_q,
   output logic                    carry_q
);
   localparam int PH_W = INT_W + FRAC_W;

   if (INT_W < 1 || FRAC_W < 2) begin : g_bad_width
      $error("refdelay_phase_acc: widths too small");
   end

   logic [FRAC_W:0] frac_sum;
   assign frac_sum = {1'b0, phase_q[FRAC_W-1:0]} + {1'b0, fcw[FRAC_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         carry_q <= 1'b0;
      end else begin
         phase_q <= phase_q + fcw;
         carry_q <= frac_sum[FRAC_W];
      end
   end

   // R3: the carry flags exactly those steps where the fraction wrapped
   p_carry_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (carry_q == (phase_q[FRAC_W-1:0] < $past(phase_q[FRAC_W-1:0]))));

   // R1: integer part advances by the command integer plus the carry
   p_int_advance_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (phase_q[PH_W-1:FRAC_W] ==
         INT_W'($past(phase_q[PH_W-1:FRAC_W]) + $past(fcw[PH_W-1:FRAC_W]) + INT_W'(carry_q))));
endmodule

// File: rtl/refdelay_scale.sv
module refdelay_scale #(
   parameter int FRAC_W    = 16,
   parameter int IG_INT_W  = 8,
   parameter int IG_FRAC_W = 16,
   parameter int CODE_W    = 6,
   parameter int RES_W     = 16
) (
   input  logic [FRAC_W-1:0]              frac_eff,
   input  logic [IG_INT_W+IG_FRAC_W-1:0]  inv_gain,
   output logic [CODE_W-1:0]              code_base,
   output logic [RES_W-1:0]               dfrac
);
   localparam int IG_W   = IG_INT_W + IG_FRAC_W;
   localparam int PROD_W = FRAC_W + IG_W;
   localparam int PT     = FRAC_W + IG_FRAC_W;
   localparam int SH     = PT - RES_W;
   localparam int SC_W   = IG_INT_W + RES_W;

   if (RES_W > PT || RES_W < 2 || CODE_W < 1) begin : g_bad_width
      $error("refdelay_scale: residue or code width out of range");
   end

   logic [FRAC_W-1:0] comp;
   logic [PROD_W-1:0] prod;
   logic [SC_W-1:0]   scaled;
   logic [IG_INT_W-1:0] pint;
   logic [RES_W-1:0]  raw;

   // complement of the fraction stands for one minus the fraction
   assign comp   = ~frac_eff;
   assign prod   = PROD_W'(comp) * PROD_W'(inv_gain);
   assign scaled = SC_W'(prod >> SH);
   assign pint   = scaled[SC_W-1:RES_W];
   assign raw    = scaled[RES_W-1:0];

   if (CODE_W < IG_INT_W) begin : g_sat
      logic over;
      assign over      = |pint[IG_INT_W-1:CODE_W];
      assign code_base = over ? {CODE_W{1'b1}} : pint[CODE_W-1:0];
      assign dfrac     = over ? '0 : raw;
   end else begin : g_nosat
      assign code_base = CODE_W'(pint);
      assign dfrac     = raw;
   end
endmodule

// File: rtl/refdelay_shaper.sv
module refdelay_shaper
   import refdelay_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int RES_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    dither_en,
   input  logic [CODE_W-1:0]       code_base,
   input  logic [RES_W-1:0]        dfrac,
   output logic [CODE_W-1:0]       code_nx,
   output logic signed [RES_W:0]   resid_nx
);
   localparam logic [RES_W:0] HALF = (RES_W+1)'(1) << (RES_W-1);

   shape_mode_e     mode;
   logic [RES_W-1:0] sd_q;
   logic [RES_W:0]   sd_sum;
   logic             inc;

   assign mode   = shape_mode_e'(dither_en);
   assign sd_sum = {1'b0, sd_q} + {1'b0, dfrac};
   assign inc    = (mode == SHAPE_DITHER) && sd_sum[RES_W];

   always_comb begin
      if (code_base == {CODE_W{1'b1}}) code_nx = code_base;
      else                              code_nx = code_base + CODE_W'(inc);
      if (mode == SHAPE_DITHER) resid_nx = '0;
      else                      resid_nx = $signed(HALF - {1'b0, dfrac});
   end

   always_ff @(posedge clk) begin
      if (rst || mode == SHAPE_RESIDUE) sd_q <= '0;
      else                              sd_q <= sd_sum[RES_W-1:0];
   end

   // R9: a residue-mode cycle leaves the modulator empty
   p_acc_clear_r9: assert property (@(posedge clk) disable iff (rst)
      !dither_en |=> (sd_q == '0));
endmodule

// File: rtl/refdelay_predictor.sv
module refdelay_predictor #(
   parameter int INT_W     = 8,
   parameter int FRAC_W    = 16,
   parameter int IG_INT_W  = 8,
   parameter int IG_FRAC_W = 16,
   parameter int CODE_W    = 6,
   parameter int RES_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [INT_W+FRAC_W-1:0]       fcw_i,
   input  logic [IG_INT_W+IG_FRAC_W-1:0] inv_gain_i,
   input  logic [FRAC_W-1:0]             pm_ofs_i,
   input  logic                          dither_en_i,
   output logic [INT_W-1:0]              ref_int_o,
   output logic [FRAC_W-1:0]             ref_frac_o,
   output logic                          carry_o,
   output logic [CODE_W-1:0]             dtc_code_o,
   output logic signed [RES_W:0]         residue_o
);
   localparam int PH_W = INT_W + FRAC_W;
   localparam logic signed [RES_W:0] HALF_S = (RES_W+1)'(1) << (RES_W-1);

   logic [PH_W-1:0]       phase_q;
   logic                  carry_q;
   logic [FRAC_W-1:0]     frac_eff;
   logic [CODE_W-1:0]     code_base;
   logic [RES_W-1:0]      dfrac;
   logic [CODE_W-1:0]     code_nx;
   logic signed [RES_W:0] resid_nx;

   refdelay_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .fcw     (fcw_i),
      .phase_q (phase_q),
      .carry_q (carry_q)
   );

   // the modulation offset touches only the fraction and wraps
   assign frac_eff = phase_q[FRAC_W-1:0] + pm_ofs_i;

   refdelay_scale #(
      .FRAC_W(FRAC_W), .IG_INT_W(IG_INT_W), .IG_FRAC_W(IG_FRAC_W),
      .CODE_W(CODE_W), .RES_W(RES_W)
   ) u_scale (
      .frac_eff  (frac_eff),
      .inv_gain  (inv_gain_i),
      .code_base (code_base),
      .dfrac     (dfrac)
   );

   refdelay_shaper #(.CODE_W(CODE_W), .RES_W(RES_W)) u_shape (
      .clk       (clk),
      .rst       (rst),
      .dither_en (dither_en_i),
      .code_base (code_base),
      .dfrac     (dfrac),
      .code_nx   (code_nx),
      .resid_nx  (resid_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_int_o  <= '0;
         ref_frac_o <= '0;
         carry_o    <= 1'b0;
         dtc_code_o <= '0;
         residue_o  <= '0;
      end else begin
         ref_int_o  <= phase_q[PH_W-1:FRAC_W];
         ref_frac_o <= frac_eff;
         carry_o    <= carry_q;
         dtc_code_o <= code_nx;
         residue_o  <= resid_nx;
      end
   end

   // R8: dithered cycles hand on no residue
   p_res_zero_dither_r8: assert property (@(posedge clk) disable iff (rst)
      dither_en_i |=> (residue_o == '0));

   // R7: the residue stays within half a code step
   p_res_range_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(dither_en_i)) |-> ((residue_o <= HALF_S) && (residue_o > -HALF_S)));
endmodule

// File: tb/refdelay_predictor_test.sv
`timescale 1ns/1ps
module refdelay_predictor_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [23:0] fcw_i = '0, inv_gain_i = '0;
   logic [15:0] pm_ofs_i = '0;
   logic dither_en_i = 1'b0;
   logic [7:0] ref_int_o;
   logic [15:0] ref_frac_o;
   logic carry_o;
   logic [5:0] dtc_code_o;
   logic signed [16:0] residue_o;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [23:0] m_phase;
   logic m_carry;
   logic [15:0] m_sd;
   longint e_int, e_frac, e_carry, e_code, e_res;

   always #2.5 clk = ~clk;

   refdelay_predictor uut (
      .clk(clk), .rst(rst), .fcw_i(fcw_i), .inv_gain_i(inv_gain_i),
      .pm_ofs_i(pm_ofs_i), .dither_en_i(dither_en_i),
      .ref_int_o(ref_int_o), .ref_frac_o(ref_frac_o), .carry_o(carry_o),
      .dtc_code_o(dtc_code_o), .residue_o(residue_o)
   );

   task automatic chk(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic model_reset();
      m_phase = '0; m_carry = 1'b0; m_sd = '0;
   endtask

   // expected outputs from the requirements, then the state advance
   task automatic model(input logic [23:0] f, input logic [23:0] g,
                        input logic [15:0] p, input logic d);
      logic [15:0] fe, comp, pfr;
      logic [39:0] prod;
      logic [16:0] s, s2;
      longint pint;
      fe = m_phase[15:0] + p;
      e_int = m_phase[23:16]; e_frac = fe; e_carry = m_carry;
      comp = ~fe;
      prod = 40'(comp) * 40'(g);
      pint = prod[39:32]; pfr = prod[31:16];
      if (pint > 63) begin pint = 63; pfr = '0; end
      if (d) begin
         s = {1'b0, m_sd} + {1'b0, pfr};
         e_code = pint + s[16];
         if (e_code > 63) e_code = 63;
         m_sd = s[15:0]; e_res = 0;
      end else begin
         e_code = pint; m_sd = '0; e_res = 32768 - longint'(pfr);
      end
      s2 = {1'b0, m_phase[15:0]} + {1'b0, f[15:0]};
      m_carry = s2[16];
      m_phase = m_phase + f;
   endtask

   // called at a falling edge: drive, clock, compare at the next falling edge
   task automatic step(input logic [23:0] f, input logic [23:0] g, input logic [15:0] p,
                       input logic d, input string ctag);
      fcw_i = f; inv_gain_i = g; pm_ofs_i = p; dither_en_i = d;
      model(f, g, p, d);
      @(posedge clk); @(negedge clk);
      chk("R1", "ref_int", ref_int_o, e_int);
      chk("R4", "ref_frac", ref_frac_o, e_frac);
      chk("R3", "carry", carry_o, e_carry);
      chk(ctag, "code", dtc_code_o, e_code);
      chk(d ? "R8" : "R7", "residue", residue_o, e_res);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10", "ref_int", ref_int_o, 0);
      chk("R10", "ref_frac", ref_frac_o, 0);
      chk("R10", "carry", carry_o, 0);
      chk("R10", "code", dtc_code_o, 0);
      chk("R10", "residue", residue_o, 0);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog: got no completion expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd19771));
      @(negedge clk);
      do_reset();

      // R11 and R2: 2.25 with gain 4.0 from reset
      for (int k = 0; k < 8; k++) begin
         step(24'h024000, 24'h040000, 16'h0, 1'b0, "R5");
         chk("R11", "code ladder", dtc_code_o, 3 - (k % 4));
         if (k == 0) chk("R2", "first frac", ref_frac_o, 0);
         if (k == 1) chk("R2", "second frac", ref_frac_o, 16'h4000);
      end

      // R4: offset wraps the fraction only
      for (int k = 0; k < 6; k++) step(24'h013000, 24'h020000, 16'hE000, 1'b0, "R5");

      // R6: large gain with tiny fraction saturates
      do_reset();
      step(24'h000000, 24'hFF0000, 16'h0010, 1'b0, "R6");
      chk("R6", "sat code", dtc_code_o, 63);
      chk("R6", "sat residue", residue_o, 32768);
      step(24'h000100, 24'h800000, 16'h0, 1'b1, "R6");

      // R8 and R9: constant fraction, dither toggled
      do_reset();
      for (int k = 0; k < 12; k++) step(24'h0, 24'h018000, 16'h0, 1'b1, "R8");
      step(24'h0, 24'h018000, 16'h0, 1'b0, "R9");
      for (int k = 0; k < 6; k++) step(24'h0, 24'h014000, 16'h4000, 1'b1, "R9");

      // seeded random mix
      begin
         logic d;
         logic [15:0] p;
         d = 1'b0;
         for (int k = 0; k < 3000; k++) begin
            if (($urandom % 8) == 0) d = ~d;
            p = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
            step(24'($urandom), 24'($urandom % 32'h500000), p, d, d ? "R8" : "R5");
            if (k == 1500) do_reset();
         end
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule